// File: doc/BRIEF.md
# Flash Program and Block-Erase Sequencer

This block is the internal sequencer of a small boot-block flash model. It takes a decoded request (program one cell, or erase one block) with an address and data, checks the write-protection conditions, and then drives a behavioural cell array through pulse-and-verify loops. Each loop has a bounded number of retries. The outcome is reported in an 8-bit status register that the host reads at any time.

The array is split into `NUM_BLK` equal blocks of `2**BLK_W` cells. The block index is the address field above bit `BLK_W`. One of these blocks is the boot block, and a strap places it at the bottom or the top of the block range. A block erase first programs every cell of the block to zero. It then applies erase pulses until the array reports the block as erased. A host may suspend an erase between pulses and resume it later, and the pulse count already spent is kept.

The array port works as follows. Each pulse lasts one cycle and is followed by one verify cycle, during which `arr_ok` is sampled. In a program verify, `arr_ok` means the cell at `arr_addr` holds `arr_data`. In an erase verify, it means every cell of the block named by `arr_addr` reads as erased.

Top module: `flash_seq`

## Requirements
- R1: After reset, status reads 0x80 and neither `arr_prog` nor `arr_erase` is asserted.
- R2: A start while `vpp_ok` is low sets status bit 3 and issues no pulse. The sequencer stays ready.
- R3: The boot block is block 0 when `boot_top`=0 and block `NUM_BLK-1` when `boot_top`=1. A request to the boot block needs `rp_hv` or `wp_hi` as well as `vpp_ok`. Without either, it is rejected with no pulse, and it sets bit 4 for a program or bit 5 for an erase. Other blocks need only `vpp_ok`.
- R4: A program applies pulses to `req_addr` with `req_data`, verifies after each pulse, and ends without error at the first passing verify.
- R5: If a program still fails its verify after `PROG_MAX` pulses (25), status bit 4 is set and the sequencer returns to ready.
- R6: An erase first programs every cell of the addressed block to zero, in ascending address order, before its first erase pulse. It places no pulse on an address outside that block.
- R7: Erase pulses repeat until a verify passes. If the verify still fails after `ERASE_MAX` pulses (1000), status bit 5 is set and the sequencer returns to ready. A failed pre-program step also sets bit 5.
- R8: Status bit 7 is 1 when ready and 0 while an operation runs. Bit 6 is erase-suspended, bit 5 is erase error, bit 4 is program error and bit 3 is VPP error. Bits 2..0 read 0.
- R9: Error bits stay set until `sts_clr` is pulsed, and that pulse clears all three.
- R10: A start is ignored while an operation runs or is suspended.
- R11: A pulse on `ers_suspend` during an erase stops it after the next failing erase verify. While stopped, bits 7 and 6 read 1 and no pulse is issued. A pulse on `ers_resume` clears bit 6 and continues with the saved pulse count.
- R12: A request whose block index is `NUM_BLK` or more is rejected with no pulse, and sets bit 4 for a program or bit 5 for an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | One-cycle start request |
| req_erase | input | 1 | 1 = block erase, 0 = program |
| req_addr | input | ADDR_W | Cell address (block index above bit BLK_W) |
| req_data | input | DATA_W | Data to program |
| vpp_ok | input | 1 | Program voltage present |
| rp_hv | input | 1 | Reset pin at super-voltage |
| wp_hi | input | 1 | Write-protect pin high |
| boot_top | input | 1 | Boot block strap: 1 = top block, 0 = bottom |
| sts_clr | input | 1 | Clears the error bits |
| ers_suspend | input | 1 | Erase suspend request pulse |
| ers_resume | input | 1 | Erase resume pulse |
| status | output | 8 | Status register |
| arr_prog | output | 1 | Program pulse |
| arr_erase | output | 1 | Erase pulse |
| arr_vfy | output | 1 | Verify cycle |
| arr_addr | output | ADDR_W | Array address |
| arr_data | output | DATA_W | Array program data |
| arr_ok | input | 1 | Verify result from the array |

## Verification
The bench drives the sequencer against an array model whose cells pass verify only after a set number of pulses. This lets it tell a single-pulse pass apart from a multi-pulse retry and from running out of retries at each cap. Erase runs record the address of every verified cell, which exposes a wrong pre-program order, a skipped cell or a stray pulse outside the block. The protection patterns separate a missing voltage, a locked boot block at either strap position, an unlocked boot block and an out-of-range block. A suspension with a start request issued during the pause shows both that the pause is quiet and that the pulse count survives it.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int DATA_W    = 8,
  parameter int BLK_W     = 2,
  parameter int NUM_BLK   = 11,
  parameter int ADDR_W    = 6,
  parameter int PROG_MAX  = 25,
  parameter int ERASE_MAX = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_start,
  input  logic              req_erase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              vpp_ok,
  input  logic              rp_hv,
  input  logic              wp_hi,
  input  logic              boot_top,
  input  logic              sts_clr,
  input  logic              ers_suspend,
  input  logic              ers_resume,
  output logic [7:0]        status,
  output logic              arr_prog,
  output logic              arr_erase,
  output logic              arr_vfy,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  input  logic              arr_ok
);

  localparam int CNT_W = $clog2(ERASE_MAX + 1);
  localparam int BIX_W = ADDR_W - BLK_W;
  localparam logic [CNT_W-1:0] P_CAP = CNT_W'(PROG_MAX);
  localparam logic [CNT_W-1:0] E_CAP = CNT_W'(ERASE_MAX);

  typedef enum logic [2:0] {S_IDLE, S_PPUL, S_PVFY, S_EPUL, S_EVFY, S_SUSP} st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic              pre, sus_pend;
  logic              vpp_err, prg_err, ers_err;

  wire [BIX_W-1:0] blk      = req_addr[ADDR_W-1:BLK_W];
  wire [BIX_W-1:0] boot_blk = boot_top ? BIX_W'(NUM_BLK - 1) : '0;
  wire             in_range = blk < BIX_W'(NUM_BLK);
  wire             unlocked = (blk != boot_blk) || rp_hv || wp_hi;
  wire             last_cell = &cur_addr[BLK_W-1:0];
  wire             erasing  = pre && (state inside {S_PPUL, S_PVFY, S_EPUL, S_EVFY});

  assign status    = {(state == S_IDLE) || (state == S_SUSP), state == S_SUSP,
                      ers_err, prg_err, vpp_err, 3'b000};
  assign arr_prog  = state == S_PPUL;
  assign arr_erase = state == S_EPUL;
  assign arr_vfy   = (state == S_PVFY) || (state == S_EVFY);
  assign arr_addr  = cur_addr;
  assign arr_data  = cur_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      cur_addr <= '0;
      cur_data <= '0;
      pre      <= 1'b0;
      sus_pend <= 1'b0;
      vpp_err  <= 1'b0;
      prg_err  <= 1'b0;
      ers_err  <= 1'b0;
    end else begin
      if (sts_clr) begin
        vpp_err <= 1'b0;
        prg_err <= 1'b0;
        ers_err <= 1'b0;
      end
      if (ers_suspend && erasing) sus_pend <= 1'b1;
      case (state)
        S_IDLE: if (req_start) begin
          if (!vpp_ok) vpp_err <= 1'b1;
          else if (!in_range || !unlocked) begin
            if (req_erase) ers_err <= 1'b1;
            else           prg_err <= 1'b1;
          end else begin
            cnt      <= '0;
            pre      <= req_erase;
            sus_pend <= 1'b0;
            cur_addr <= req_erase ? {blk, BLK_W'(0)} : req_addr;
            cur_data <= req_erase ? '0 : req_data;
            state    <= S_PPUL;
          end
        end
        S_PPUL: begin
          cnt   <= cnt + 1'b1;
          state <= S_PVFY;
        end
        S_PVFY: begin
          if (arr_ok) begin
            cnt <= '0;
            if (!pre)           state <= S_IDLE;
            else if (last_cell) state <= S_EPUL;
            else begin
              cur_addr <= cur_addr + 1'b1;
              state    <= S_PPUL;
            end
          end else if (cnt >= P_CAP) begin
            if (pre) ers_err <= 1'b1;
            else     prg_err <= 1'b1;
            sus_pend <= 1'b0;
            state    <= S_IDLE;
          end else state <= S_PPUL;
        end
        S_EPUL: begin
          cnt   <= cnt + 1'b1;
          state <= S_EVFY;
        end
        S_EVFY: begin
          if (arr_ok) begin
            sus_pend <= 1'b0;
            state    <= S_IDLE;
          end else if (cnt >= E_CAP) begin
            ers_err  <= 1'b1;
            sus_pend <= 1'b0;
            state    <= S_IDLE;
          end else if (sus_pend || ers_suspend) begin
            sus_pend <= 1'b0;
            state    <= S_SUSP;
          end else state <= S_EPUL;
        end
        S_SUSP: if (ers_resume) state <= S_EPUL;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_verify_follows: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |=> arr_vfy);
  a_r5_prog_cap: assert property (@(posedge clk) disable iff (!rst_n)
    arr_prog |-> cnt < P_CAP);
  a_r7_erase_cap: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> cnt < E_CAP);
  a_r2_vpp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !status[6] && req_start && !vpp_ok && !sts_clr) |=> (status[3] && status[7]));
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !sts_clr) |=> status[4]);
  a_r11_susp_after_vfy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(arr_vfy));

endmodule

// File: tb/flash_seq_bench.sv
`timescale 1ns/1ps
module flash_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_start = 0, req_erase = 0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic vpp_ok = 1, rp_hv = 0, wp_hi = 0, boot_top = 0;
  logic sts_clr = 0, ers_suspend = 0, ers_resume = 0;
  logic [7:0] status;
  logic arr_prog, arr_erase, arr_vfy, arr_ok;
  logic [5:0] arr_addr;
  logic [7:0] arr_data;

  flash_seq u_flash_seq (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int p_need = 1, e_need = 1, blk_sel = 0;
  int pcnt = 0, ecnt = 0, tot_p = 0, tot_e = 0, nok = 0, nok_at_e = 0, out_cnt = 0;
  logic last_erase = 0;
  logic [5:0] ok_log [0:255];

  assign arr_ok = last_erase ? (ecnt >= e_need) : (pcnt >= p_need);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_prog) begin tot_p <= tot_p + 1; pcnt <= pcnt + 1; last_erase <= 0; end
    if (arr_erase) begin tot_e <= tot_e + 1; ecnt <= ecnt + 1; last_erase <= 1; nok_at_e <= nok; end
    if ((arr_prog || arr_erase) && (int'(arr_addr >> 2) != blk_sel)) out_cnt <= out_cnt + 1;
    if (arr_vfy && arr_ok && !last_erase) begin
      ok_log[nok % 256] <= arr_addr;
      nok <= nok + 1;
      pcnt <= 0;
    end
    if (status[7] && !status[6]) begin pcnt <= 0; ecnt <= 0; end
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic go(input logic ers, input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    req_start = 1; req_erase = ers; req_addr = a; req_data = d;
    @(negedge clk);
    req_start = 0;
    while (!(status[7] && !status[6])) @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk); sts_clr = 1; @(negedge clk); sts_clr = 0;
  endtask

  task automatic t_reset();
    chk(status == 8'h80, "R1 status", status, 8'h80);
    chk(!arr_prog && !arr_erase, "R1 strobes", arr_prog + arr_erase, 0);
  endtask

  task automatic t_vpp();
    int p0 = tot_p;
    vpp_ok = 0; blk_sel = 1;
    go(0, 6'd5, 8'h3C);
    chk(status == 8'h88, "R2 vpp status", status, 8'h88);
    chk(tot_p == p0, "R2 no pulse", tot_p - p0, 0);
    vpp_ok = 1;
    clear();
    chk(status == 8'h80, "R9 clear", status, 8'h80);
  endtask

  task automatic t_prog_ok();
    int p0 = tot_p;
    p_need = 3; blk_sel = 1;
    go(0, 6'd6, 8'hA5);
    chk(tot_p - p0 == 3, "R4 pulses", tot_p - p0, 3);
    chk(ok_log[(nok - 1) % 256] == 6'd6, "R4 address", ok_log[(nok - 1) % 256], 6);
    chk(arr_data == 8'hA5, "R4 data", arr_data, 8'hA5);
    chk(status == 8'h80, "R4 status", status, 8'h80);
  endtask

  task automatic t_prog_cap();
    int p0 = tot_p;
    p_need = 99; blk_sel = 2;
    go(0, 6'd9, 8'h11);
    chk(tot_p - p0 == 25, "R5 pulses", tot_p - p0, 25);
    chk(status == 8'h90, "R5 status", status, 8'h90);
    repeat (5) @(negedge clk);
    chk(status == 8'h90, "R9 sticky", status, 8'h90);
    clear();
    chk(status == 8'h80, "R9 cleared", status, 8'h80);
  endtask

  task automatic t_erase_ok();
    int p0 = tot_p, e0 = tot_e, n0 = nok, o0 = out_cnt;
    bit ord = 1;
    p_need = 2; e_need = 5; blk_sel = 3;
    go(1, 6'd14, 8'hFF);
    chk(tot_p - p0 == 8, "R6 preprog pulses", tot_p - p0, 8);
    chk(nok - n0 == 4, "R6 cells", nok - n0, 4);
    for (int i = 0; i < 4; i++) if (ok_log[(n0 + i) % 256] != 6'(12 + i)) ord = 0;
    chk(ord, "R6 order", ord, 1);
    chk(nok_at_e - n0 == 4, "R6 before erase", nok_at_e - n0, 4);
    chk(out_cnt == o0, "R6 in block", out_cnt - o0, 0);
    chk(tot_e - e0 == 5, "R7 erase pulses", tot_e - e0, 5);
    chk(status == 8'h80, "R7 status", status, 8'h80);
  endtask

  task automatic t_erase_cap();
    int e0 = tot_e;
    p_need = 1; e_need = 5000; blk_sel = 4;
    go(1, 6'd16, 8'h00);
    chk(tot_e - e0 == 1000, "R7 cap pulses", tot_e - e0, 1000);
    chk(status == 8'hA0, "R7 cap status", status, 8'hA0);
    clear();
  endtask

  task automatic t_boot();
    int p0 = tot_p;
    p_need = 1; e_need = 1;
    boot_top = 0; blk_sel = 0;
    go(1, 6'd1, 8'h00);
    chk(status == 8'hA0 && tot_p == p0, "R3 bottom locked", status, 8'hA0);
    clear();
    wp_hi = 1;
    go(1, 6'd1, 8'h00);
    chk(status == 8'h80 && tot_p - p0 == 4, "R3 wp unlock", tot_p - p0, 4);
    wp_hi = 0; boot_top = 1; blk_sel = 10;
    p0 = tot_p;
    go(0, 6'd41, 8'h5A);
    chk(status == 8'h90 && tot_p == p0, "R3 top locked", status, 8'h90);
    clear();
    rp_hv = 1;
    go(0, 6'd41, 8'h5A);
    chk(status == 8'h80 && tot_p - p0 == 1, "R3 rp unlock", tot_p - p0, 1);
    rp_hv = 0; blk_sel = 0; p0 = tot_p;
    go(0, 6'd2, 8'h77);
    chk(status == 8'h80 && tot_p - p0 == 1, "R3 bottom free when top", tot_p - p0, 1);
    boot_top = 0;
  endtask

  task automatic t_range();
    int p0 = tot_p;
    blk_sel = 15;
    go(0, 6'd60, 8'h01);
    chk(status == 8'h90 && tot_p == p0, "R12 range prog", status, 8'h90);
    clear();
    go(1, 6'd48, 8'h01);
    chk(status == 8'hA0 && tot_p == p0, "R12 range erase", status, 8'hA0);
    clear();
  endtask

  task automatic t_busy();
    int o0 = out_cnt, p0 = tot_p;
    p_need = 3; e_need = 4; blk_sel = 5;
    @(negedge clk);
    req_start = 1; req_erase = 1; req_addr = 6'd20;
    @(negedge clk);
    req_erase = 0; req_addr = 6'd4; req_data = 8'h99;
    chk(status[7] == 0, "R8 busy bit", status[7], 0);
    repeat (3) @(negedge clk);
    req_start = 0;
    while (!(status[7] && !status[6])) @(negedge clk);
    chk(out_cnt == o0, "R10 start ignored", out_cnt - o0, 0);
    chk(tot_p - p0 == 12 && status == 8'h80, "R10 erase intact", tot_p - p0, 12);
  endtask

  task automatic t_suspend();
    int e0 = tot_e, es, ps, guard = 0;
    p_need = 1; e_need = 6; blk_sel = 2;
    @(negedge clk);
    req_start = 1; req_erase = 1; req_addr = 6'd8;
    @(negedge clk); req_start = 0;
    while (tot_e - e0 < 2) @(negedge clk);
    ers_suspend = 1; @(negedge clk); ers_suspend = 0;
    while (!status[6] && guard < 50) begin @(negedge clk); guard++; end
    chk(status == 8'hC0, "R11 suspended status", status, 8'hC0);
    es = tot_e; ps = tot_p;
    req_start = 1; req_erase = 0; req_addr = 6'd4; @(negedge clk); req_start = 0;
    repeat (20) @(negedge clk);
    chk(tot_e == es && tot_p == ps, "R11 quiet", tot_e - es, 0);
    chk(tot_e - e0 < 6, "R11 paused early", tot_e - e0, 3);
    ers_resume = 1; @(negedge clk); ers_resume = 0;
    chk(status[6] == 0, "R11 resume clears", status[6], 0);
    while (!(status[7] && !status[6])) @(negedge clk);
    chk(tot_e - e0 == 6, "R11 count kept", tot_e - e0, 6);
    chk(tot_p == ps && status == 8'h80, "R10 ignored while suspended", tot_p - ps, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vpp();
    t_prog_ok();
    t_prog_cap();
    t_erase_ok();
    t_erase_cap();
    t_boot();
    t_range();
    t_busy();
    t_suspend();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule